// File: doc/BRIEF.md
# External Bus Microcycle Sequencer

This block runs one read or write access on a shared 8-bit external bus once the bus has already been granted. A request arrives with a 16-bit address, an output byte for writes, and three flags that describe the instruction context: halt, delay and first-byte fetch. The block then steps through a fixed series of phases and answers with a one-clock done pulse. For a read, it also returns the captured input byte.

The access begins with an address phase one clock long. In that phase the active-low address strobe is low, the twelve low address bits sit on their own lines, and the data bus carries a combined byte. Its low nibble holds the top four address bits and its high nibble holds a status code that tells external logic what kind of access follows. Next comes a strobe phase, two clocks by default. In it the active-low read strobe or write strobe is asserted. An external hold input can extend this phase by one clock for each clock it is high. A single recovery clock ends the access, and done is high during that clock.

The hold input lengthens only the strobe phase. Every access without hold therefore has the same length. Bus arbitration and internal machine cycles are handled elsewhere.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, the address, read and write strobes are high (inactive), the data bus output enable is low, done is low, and the low address lines and captured read data are zero.
- R2: A start seen while idle makes the next clock the address phase, which lasts exactly one clock. In it the address strobe is low, the output enable is high, the low address lines show address bits 11:0, and data bus bits 3:0 show address bits 15:12.
- R3: During the address phase, data bus bits 7..4 carry the status code: bit 7 = halt flag, bit 6 = delay flag, bit 5 = fetch flag, bit 4 = 1 for a read and 0 for a write. The codes are: instruction fetch read 0011, halt read 1011, delay read 0101, plain data read 0001, plain data write 0000.
- R4: In a read access, the read strobe is low for 2 clocks right after the address phase, and the output enable is low during all of them.
- R5: In a write access, the write strobe is low for 2 clocks right after the address phase. The output enable is high and the data bus shows the write byte through the strobe phase and the recovery clock.
- R6: Each clock edge during the strobe phase at which hold is high keeps the strobe asserted one more clock. The strobe length is 2 plus the number of such edges.
- R7: Read data is captured from the input bus at the clock edge where the read strobe deasserts. It is held unchanged until the next read finishes; writes do not alter it.
- R8: Done is high for exactly one clock: the recovery clock right after the strobe phase. All strobes are inactive in that clock.
- R9: At most one of the three active-low strobes is low in any clock.
- R10: A start seen while an access is in progress is ignored. No new address phase follows, and the low address lines keep the current access's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a new access (taken only while idle) |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Byte to write |
| halt_i | input | 1 | Halt instruction context flag |
| delay_i | input | 1 | Delay instruction context flag |
| fetch_i | input | 1 | First-byte instruction fetch flag |
| hold_i | input | 1 | Stretches the strobe phase while high |
| addr_lo_o | output | 12 | Low address lines |
| dbus_o | output | 8 | Data bus output value |
| dbus_oe_o | output | 1 | Data bus output enable |
| dbus_i | input | 8 | Data bus input value |
| ads_n_o | output | 1 | Active-low address/status strobe |
| rds_n_o | output | 1 | Active-low read strobe |
| wds_n_o | output | 1 | Active-low write strobe |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Captured read byte |

## Verification
The bench puts a wrong byte on the input bus in every strobe clock except the last one. A design that captures read data too early, or again after the strobe ends, therefore returns the wrong value. Hold is applied for several clocks in both read and write accesses. A counter that does not freeze, or that resets while hold is high, produces a strobe of the wrong length. All five status codes are driven, so swapped flag bits or an inverted read bit show up on the data bus during the address phase. A start pulse placed in the middle of an access catches a design that restarts, or that overwrites the latched address on a second request.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_STRB = 2'd2,
      PH_RECV = 2'd3
   } phase_e;
endpackage

// File: rtl/bcs_status_enc.sv
module bcs_status_enc #(
   parameter int ST_W = 4
) (
   input  logic            halt_i,
   input  logic            delay_i,
   input  logic            fetch_i,
   input  logic            is_write_i,
   output logic [ST_W-1:0] status_o
);
   generate
      if (ST_W != 4) begin : g_bad_width
         $error("bcs_status_enc: status field must be 4 bits");
      end
   endgenerate

   // MSB to LSB: halt, delay, fetch, read
   assign status_o = {halt_i, delay_i, fetch_i, ~is_write_i};
endmodule

// File: rtl/bcs_phase_ctl.sv
module bcs_phase_ctl
   import bcs_pkg::*;
#(
   parameter int STROBE_CLKS = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start_i,
   input  logic   hold_i,
   output phase_e phase_o,
   output logic   strobe_end_o
);
   phase_e ph_q, ph_d;
   logic   last_strobe;

   generate
      if (STROBE_CLKS < 1) begin : g_bad_len
         $error("bcs_phase_ctl: STROBE_CLKS must be at least 1");
      end
      if (STROBE_CLKS == 1) begin : g_single
         assign last_strobe = 1'b1;
      end else begin : g_counted
         localparam int CW = $clog2(STROBE_CLKS);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (ph_q != PH_STRB)
               cnt_q <= '0;
            else if (!hold_i && !last_strobe)
               cnt_q <= cnt_q + 1'b1;
         end
         assign last_strobe = (cnt_q == CW'(STROBE_CLKS - 1));
      end
   endgenerate

   assign strobe_end_o = (ph_q == PH_STRB) && !hold_i && last_strobe;

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE: if (start_i) ph_d = PH_ADDR;
         PH_ADDR: ph_d = PH_STRB;
         PH_STRB: if (strobe_end_o) ph_d = PH_RECV;
         PH_RECV: ph_d = PH_IDLE;
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   assign phase_o = ph_q;

   // hold keeps the strobe phase alive
   assert_hold_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_STRB && hold_i) |=> (ph_q == PH_STRB));
   // address phase lasts one clock
   assert_addr_one_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_ADDR) |=> (ph_q == PH_STRB));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
   import bcs_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int HI_W        = 4,
   parameter int STROBE_CLKS = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic                      wr_i,
   input  logic [ADDR_W-1:0]         addr_i,
   input  logic [DATA_W-1:0]         wdata_i,
   input  logic                      halt_i,
   input  logic                      delay_i,
   input  logic                      fetch_i,
   input  logic                      hold_i,
   output logic [ADDR_W-HI_W-1:0]    addr_lo_o,
   output logic [DATA_W-1:0]         dbus_o,
   output logic                      dbus_oe_o,
   input  logic [DATA_W-1:0]         dbus_i,
   output logic                      ads_n_o,
   output logic                      rds_n_o,
   output logic                      wds_n_o,
   output logic                      done_o,
   output logic [DATA_W-1:0]         rdata_o
);
   localparam int LO_W = ADDR_W - HI_W;
   localparam int ST_W = DATA_W - HI_W;

   generate
      if (HI_W < 1 || HI_W >= ADDR_W) begin : g_bad_hi
         $error("bus_cycle_seq: HI_W out of range");
      end
      if (ST_W != 4) begin : g_bad_st
         $error("bus_cycle_seq: DATA_W - HI_W must leave a 4-bit status field");
      end
   endgenerate

   phase_e            phase;
   logic              strobe_end;
   logic              accept;
   logic [ST_W-1:0]   status_new;
   logic [ST_W-1:0]   status_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              wr_q;
   logic [DATA_W-1:0] rdata_q;

   bcs_phase_ctl #(.STROBE_CLKS(STROBE_CLKS)) u_phase (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .hold_i       (hold_i),
      .phase_o      (phase),
      .strobe_end_o (strobe_end)
   );

   bcs_status_enc #(.ST_W(ST_W)) u_status (
      .halt_i     (halt_i),
      .delay_i    (delay_i),
      .fetch_i    (fetch_i),
      .is_write_i (wr_i),
      .status_o   (status_new)
   );

   assign accept = start_i && (phase == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         wdata_q  <= '0;
         wr_q     <= 1'b0;
         status_q <= '0;
      end else if (accept) begin
         addr_q   <= addr_i;
         wdata_q  <= wdata_i;
         wr_q     <= wr_i;
         status_q <= status_new;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (strobe_end && !wr_q)
         rdata_q <= dbus_i;
   end

   always_comb begin
      ads_n_o   = !(phase == PH_ADDR);
      rds_n_o   = !(phase == PH_STRB && !wr_q);
      wds_n_o   = !(phase == PH_STRB && wr_q);
      dbus_oe_o = (phase == PH_ADDR) ||
                  (wr_q && (phase == PH_STRB || phase == PH_RECV));
      if (phase == PH_ADDR)
         dbus_o = {status_q, addr_q[ADDR_W-1 -: HI_W]};
      else if (dbus_oe_o)
         dbus_o = wdata_q;
      else
         dbus_o = '0;
   end

   assign addr_lo_o = addr_q[LO_W-1:0];
   assign done_o    = (phase == PH_RECV);
   assign rdata_o   = rdata_q;

   assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~ads_n_o, ~rds_n_o, ~wds_n_o}) <= 1);
   assert_oe_off_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rds_n_o |-> !dbus_oe_o);
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !ads_n_o) |=> $stable(addr_lo_o));
   assert_rdata_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rds_n_o) |=> $stable(rdata_o));
endmodule

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;
   localparam int NSTRB = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        wr_i = 1'b0;
   logic [15:0] addr_i = '0;
   logic [7:0]  wdata_i = '0;
   logic        halt_i = 1'b0, delay_i = 1'b0, fetch_i = 1'b0;
   logic        hold_i = 1'b0;
   logic [11:0] addr_lo_o;
   logic [7:0]  dbus_o;
   logic        dbus_oe_o;
   logic [7:0]  dbus_i = '0;
   logic        ads_n_o, rds_n_o, wds_n_o, done_o;
   logic [7:0]  rdata_o;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   bus_cycle_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .halt_i(halt_i),
      .delay_i(delay_i), .fetch_i(fetch_i), .hold_i(hold_i),
      .addr_lo_o(addr_lo_o), .dbus_o(dbus_o), .dbus_oe_o(dbus_oe_o),
      .dbus_i(dbus_i), .ads_n_o(ads_n_o), .rds_n_o(rds_n_o),
      .wds_n_o(wds_n_o), .done_o(done_o), .rdata_o(rdata_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic t_reset();
      chk(ads_n_o && rds_n_o && wds_n_o, "R1 strobes", {ads_n_o, rds_n_o, wds_n_o}, 3'b111);
      chk(!dbus_oe_o, "R1 oe", dbus_oe_o, 0);
      chk(!done_o, "R1 done", done_o, 0);
      chk(addr_lo_o == 12'h0 && rdata_o == 8'h0, "R1 regs", {addr_lo_o, rdata_o}, 0);
   endtask

   // one full access; holds = number of strobe edges with hold high
   task automatic run_access(input bit wr, input logic [15:0] a, input logic [7:0] wd,
                             input bit h, input bit d, input bit f,
                             input int holds, input logic [7:0] rdin);
      int n = 0;
      int held = 0;
      bit seen = 0;
      int total = NSTRB + holds;
      logic [7:0] prev_rdata;
      @(negedge clk);
      start_i = 1'b1; wr_i = wr; addr_i = a; wdata_i = wd;
      halt_i = h; delay_i = d; fetch_i = f; dbus_i = ~rdin;
      prev_rdata = rdata_o;
      @(negedge clk);
      start_i = 1'b0;
      chk(!ads_n_o && rds_n_o && wds_n_o, "R2 address phase strobes", {ads_n_o, rds_n_o, wds_n_o}, 3'b011);
      chk(dbus_oe_o, "R2 oe in address phase", dbus_oe_o, 1);
      chk(addr_lo_o == a[11:0], "R2 low address", addr_lo_o, a[11:0]);
      chk(dbus_o == {h, d, f, ~wr, a[15:12]}, "R3 status and high address", dbus_o, {h, d, f, ~wr, a[15:12]});
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (done_o) begin seen = 1; break; end
         n++;
         chk(ads_n_o, "R9 address strobe off in strobe phase", ads_n_o, 1);
         if (wr) begin
            chk(!wds_n_o && rds_n_o, "R5 write strobe", {rds_n_o, wds_n_o}, 2'b10);
            chk(dbus_oe_o && dbus_o == wd, "R5 write data", dbus_o, wd);
         end else begin
            chk(!rds_n_o && wds_n_o, "R4 read strobe", {rds_n_o, wds_n_o}, 2'b01);
            chk(!dbus_oe_o, "R4 oe off while reading", dbus_oe_o, 0);
         end
         hold_i = (held < holds);
         if (hold_i) held++;
         dbus_i = (n == total) ? rdin : ~rdin;
      end
      hold_i = 1'b0;
      chk(seen, "R8 done seen", seen, 1);
      chk(n == total, wr ? "R6 R5 strobe length" : "R6 R4 strobe length", n, total);
      chk(ads_n_o && rds_n_o && wds_n_o, "R8 strobes off with done", {ads_n_o, rds_n_o, wds_n_o}, 3'b111);
      chk(dbus_oe_o == wr, "R5 oe in recovery", dbus_oe_o, wr);
      if (wr)
         chk(rdata_o == prev_rdata, "R7 write leaves read data", rdata_o, prev_rdata);
      else
         chk(rdata_o == rdin, "R7 captured read data", rdata_o, rdin);
      dbus_i = 8'hC3;
      @(negedge clk);
      chk(!done_o, "R8 done one clock", done_o, 0);
      chk(ads_n_o && !dbus_oe_o, "R8 idle after recovery", {ads_n_o, dbus_oe_o}, 2'b10);
      if (!wr)
         chk(rdata_o == rdin, "R7 read data held", rdata_o, rdin);
   endtask

   task automatic t_busy_start();
      @(negedge clk);
      start_i = 1'b1; wr_i = 1'b0; addr_i = 16'h1234; halt_i = 0; delay_i = 0; fetch_i = 0;
      @(negedge clk);
      start_i = 1'b1; wr_i = 1'b1; addr_i = 16'hFEDC;   // address phase: start again
      @(negedge clk);
      start_i = 1'b1;                                   // strobe phase: start again
      @(negedge clk);
      @(negedge clk);                                   // recovery
      start_i = 1'b0;
      chk(done_o, "R10 first access completes", done_o, 1);
      chk(addr_lo_o == 12'h234, "R10 address kept", addr_lo_o, 12'h234);
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         chk(ads_n_o && rds_n_o && wds_n_o, "R10 no second access", {ads_n_o, rds_n_o, wds_n_o}, 3'b111);
         chk(addr_lo_o == 12'h234, "R10 address unchanged", addr_lo_o, 12'h234);
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      run_access(1'b0, 16'hA123, 8'h00, 0, 0, 1, 0, 8'h5E);  // fetch 0011
      run_access(1'b0, 16'h3FFF, 8'h00, 1, 0, 1, 0, 8'h81);  // halt 1011
      run_access(1'b0, 16'h7001, 8'h00, 0, 1, 0, 0, 8'h3C);  // delay 0101
      run_access(1'b0, 16'hC0DE, 8'h00, 0, 0, 0, 0, 8'hA7);  // data read 0001
      run_access(1'b1, 16'h5AA5, 8'h96, 0, 0, 0, 0, 8'h00);  // data write 0000
      run_access(1'b0, 16'hFFFF, 8'h00, 0, 0, 0, 2, 8'h42);  // held read
      run_access(1'b1, 16'h0000, 8'hE1, 0, 0, 0, 3, 8'h00);  // held write
      t_busy_start();
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule